// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps a 32-bit effective address to a physical address through a small set of block translation entries. Each entry has two 32-bit words: an upper word that gives the block's effective page index, its size and the privilege levels it serves, and a lower word that gives the physical page index and the access rights. There are two banks of entries. Instruction fetches search one bank and loads and stores search the other.

A lookup starts with a one-cycle request strobe. The request carries the address, the access kind and the privilege mode. One cycle later the unit returns a registered result. The result flags a hit and gives the physical address and the granted rights. It also flags a violation when the access needs a right that the entry does not grant. A miss only reports no hit; the surrounding translation logic decides what to do next. Entries are loaded one word at a time through a write port.

A build parameter selects the word layout. The standard layout has separate supervisor and user valid bits and an 11-bit size field. The legacy layout has a single valid bit and a 6-bit size field, both in the lower word, and it takes its rights keys from the upper word.

Top module: `bxm_lookup`

## Requirements
- R1: After reset, `rsp_valid` is low and every entry in both banks is invalid, so every lookup misses.
- R2: A fetch (`req_acc` = 2) searches the instruction bank (`wr_instr` = 1). A load (`req_acc` = 0) or a store (`req_acc` = 1) searches the data bank (`wr_instr` = 0).
- R3: Standard layout: an entry can hit only if its upper-word bit 1 is set when `req_user` = 0 (supervisor), or its upper-word bit 0 is set when `req_user` = 1 (user).
- R4: Standard layout: bits 31:17 of the upper word hold the block page index, and bits 12:2 hold an 11-bit size field. A set size bit j makes address bit 17+j a don't-care. Address bits 31:28 and address bits whose size bit is clear must equal the upper word.
- R5: On a hit, `rsp_pa` = (lower word AND mask) OR (address AND NOT mask). The mask is ones on the compared page bits and zero elsewhere, including bits 16:0.
- R6: When several entries hit, the lowest-numbered entry supplies the result.
- R7: `rsp_prot` is {read, write, execute}. Standard layout lower-word bits 1:0 grant the following: 0 gives none, 1 gives read+execute, 2 gives all, 3 gives read+execute. A load needs read, a store needs write and a fetch needs execute. `rsp_viol` is set on a hit that lacks the needed right.
- R8: On a miss, `rsp_hit`, `rsp_viol`, `rsp_prot` and `rsp_pa` are all zero.
- R9: The result appears with `rsp_valid` high exactly one cycle after `req`. `rsp_valid` is low in cycles that follow no request, and the result fields hold their values in those cycles.
- R10: A word written in the same cycle as a request is not seen by that request. It is seen by the next request.
- R11: Legacy layout: lower-word bit 6 is the only valid bit. Lower-word bits 5:0 form a size field whose bit j frees address bit 17+j.
- R12: Legacy layout: the rights key is upper-word bit 3 in supervisor mode and bit 2 in user mode, and upper-word bits 1:0 select the rights. Key 0 gives all rights, except that code 3 gives read+execute. Key 1 uses the code table of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry word |
| wr_instr | input | 1 | Bank of the write: 1 instruction, 0 data |
| wr_idx | input | IDX_W | Entry number of the write |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word to write |
| req | input | 1 | Lookup strobe |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| rsp_valid | output | 1 | Result valid, one cycle after req |
| rsp_hit | output | 1 | An entry matched |
| rsp_viol | output | 1 | Matched entry lacks the needed right |
| rsp_pa | output | 32 | Physical address, zero on miss |
| rsp_prot | output | 3 | Granted rights {read, write, execute} |

## Verification
An entry write and a lookup can happen in the same cycle, and the lookup must not see the new word. The bench starts a user-mode load while, at the same clock edge, it rewrites the upper word of the entry that the load will select, clearing its valid bits. It expects the old hit, address and rights. It then repeats the load and expects the new contents to apply, which means a miss in the standard layout. A near-exhaustive sweep over 512 page indices, three access kinds and both modes, run against overlapping entries in both layouts, checks the priority and the masking against an arithmetic model of the requirements.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    localparam int EA_W     = 32;
    localparam int PAGE_LSB = 17;
    localparam int PAGE_W   = EA_W - PAGE_LSB;
    localparam int BL_W     = 11;
    localparam int LBL_W    = 6;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    typedef struct packed {
        logic            hit;
        logic [EA_W-1:0] pa;
        rights_t         prot;
    } match_t;

    // Rights that an access of a given kind requires.
    function automatic rights_t need_of(acc_e a);
        rights_t n;
        n = '0;
        case (a)
            ACC_LOAD:  n.r = 1'b1;
            ACC_STORE: n.w = 1'b1;
            ACC_FETCH: n.x = 1'b1;
            default:   n = '0;
        endcase
        return n;
    endfunction

    // Rights granted by a key bit and a two-bit protection code.
    function automatic rights_t grant_of(logic key, logic [1:0] pp);
        rights_t g;
        if (!key) begin
            g = (pp == 2'b11) ? 3'b101 : 3'b111;
        end else begin
            case (pp)
                2'b00:   g = 3'b000;
                2'b10:   g = 3'b111;
                default: g = 3'b101;
            endcase
        end
        return g;
    endfunction

    // Standard layout: high nibble always compared, size bits free page bits.
    function automatic logic [EA_W-1:0] std_mask(logic [BL_W-1:0] bl);
        return {{(PAGE_W-BL_W){1'b1}}, ~bl, {PAGE_LSB{1'b0}}};
    endfunction

    // Legacy layout: size field shifted into the page index and cleared there.
    function automatic logic [EA_W-1:0] legacy_mask(logic [LBL_W-1:0] bl);
        logic [EA_W-1:0] sz;
        sz = {{(EA_W-LBL_W){1'b0}}, bl} << PAGE_LSB;
        return {{PAGE_W{1'b1}}, {PAGE_LSB{1'b0}}} & ~sz;
    endfunction

endpackage

// File: rtl/bxm_entry.sv
module bxm_entry
    import bxm_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic [EA_W-1:0] upper,
    input  logic [EA_W-1:0] lower,
    input  logic [EA_W-1:0] ea,
    input  logic            user,
    output match_t          res
);

    logic            valid;
    logic [EA_W-1:0] mask;
    rights_t         prot;

    generate
        if (LEGACY) begin : g_legacy
            logic unused_bits;
            assign unused_bits = ^{upper[PAGE_LSB-1:4], lower[PAGE_LSB-1:LBL_W+1]};
            always_comb begin
                valid = lower[LBL_W];
                mask  = legacy_mask(lower[LBL_W-1:0]);
                prot  = grant_of(user ? upper[2] : upper[3], upper[1:0]);
            end
        end else begin : g_standard
            logic unused_bits;
            assign unused_bits = ^{upper[PAGE_LSB-1:BL_W+2], lower[PAGE_LSB-1:2]};
            always_comb begin
                valid = user ? upper[0] : upper[1];
                mask  = std_mask(upper[BL_W+1:2]);
                prot  = grant_of(1'b1, lower[1:0]);
            end
        end
    endgenerate

    always_comb begin
        res.hit  = valid && ((ea & mask) == (upper & mask));
        res.pa   = res.hit ? ((lower & mask) | (ea & ~mask)) : '0;
        res.prot = res.hit ? prot : '0;
    end

endmodule

// File: rtl/bxm_pick.sv
module bxm_pick
    import bxm_pkg::*;
#(
    parameter int N = 4
) (
    input  match_t [N-1:0] cand,
    output match_t         win
);

    // Scan from the top so the lowest-numbered hit is written last.
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i].hit) win = cand[i];
        end
    end

endmodule

// File: rtl/bxm_lookup.sv
module bxm_lookup
    import bxm_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter bit LEGACY  = 1'b0,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_instr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_upper,
    input  logic [EA_W-1:0]  wr_data,
    input  logic             req,
    input  logic [EA_W-1:0]  req_ea,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_viol,
    output logic [EA_W-1:0]  rsp_pa,
    output logic [2:0]       rsp_prot
);

    localparam int BANKS = 2;

    logic [EA_W-1:0] up_q [BANKS][ENTRIES];
    logic [EA_W-1:0] lo_q [BANKS][ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BANKS; b++) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    up_q[b][i] <= '0;
                    lo_q[b][i] <= '0;
                end
            end
        end else if (wr_en) begin
            if (wr_upper) up_q[wr_instr][wr_idx] <= wr_data;
            else          lo_q[wr_instr][wr_idx] <= wr_data;
        end
    end

    acc_e acc;
    logic bank;
    assign acc  = acc_e'(req_acc);
    assign bank = (acc == ACC_FETCH);

    match_t [ENTRIES-1:0] cand;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            bxm_entry #(.LEGACY(LEGACY)) u_entry (
                .upper (up_q[bank][i]),
                .lower (lo_q[bank][i]),
                .ea    (req_ea),
                .user  (req_user),
                .res   (cand[i])
            );
        end
    endgenerate

    match_t  win;
    rights_t need;
    logic    viol;

    bxm_pick #(.N(ENTRIES)) u_pick (
        .cand (cand),
        .win  (win)
    );

    assign need = need_of(acc);
    assign viol = win.hit && ((need & ~win.prot) != 3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_pa    <= '0;
            rsp_prot  <= '0;
        end else begin
            rsp_valid <= req;
            if (req) begin
                rsp_hit  <= win.hit;
                rsp_viol <= viol;
                rsp_pa   <= win.pa;
                rsp_prot <= win.prot;
            end
        end
    end

    assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rsp_valid);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable({rsp_hit, rsp_viol, rsp_pa, rsp_prot}));

    assert_miss_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_viol && rsp_prot == 3'b000));

    assert_granted_covers_need_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !rsp_viol)
        |-> ((need_of(acc_e'($past(req_acc))) & ~rsp_prot) == 3'b000));

    assert_viol_lacks_right_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_viol)
        |-> (rsp_hit && ((need_of(acc_e'($past(req_acc))) & ~rsp_prot) != 3'b000)));

endmodule

// File: tb/bxm_lookup_bench.sv
`timescale 1ns/1ps
module bxm_lookup_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, wr_en, wr_instr, wr_upper, req, req_user;
    logic [1:0]  wr_idx, req_acc;
    logic [31:0] wr_data, req_ea;

    logic        s_valid, s_hit, s_viol, l_valid, l_hit, l_viol;
    logic [31:0] s_pa, l_pa;
    logic [2:0]  s_prot, l_prot;

    bxm_lookup #(.ENTRIES(4), .LEGACY(1'b0)) u_bxm_lookup (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_instr(wr_instr), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .req(req), .req_ea(req_ea),
        .req_acc(req_acc), .req_user(req_user), .rsp_valid(s_valid), .rsp_hit(s_hit),
        .rsp_viol(s_viol), .rsp_pa(s_pa), .rsp_prot(s_prot));

    bxm_lookup #(.ENTRIES(4), .LEGACY(1'b1)) u_bxm_lookup_legacy (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_instr(wr_instr), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .req(req), .req_ea(req_ea),
        .req_acc(req_acc), .req_user(req_user), .rsp_valid(l_valid), .rsp_hit(l_hit),
        .rsp_viol(l_viol), .rsp_pa(l_pa), .rsp_prot(l_prot));

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] sh_up [2][4];
    logic [31:0] sh_lo [2][4];

    task automatic chk(string tag, string inst, logic [37:0] act, logic [37:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, inst, act, exp);
        end
    endtask

    function automatic logic [2:0] rt(logic key, logic [1:0] pp);
        case ({key, pp})
            3'b011:  return 3'b101;
            3'b000, 3'b001, 3'b010: return 3'b111;
            3'b100:  return 3'b000;
            3'b110:  return 3'b111;
            default: return 3'b101;
        endcase
    endfunction

    // Returns {hit, viol, pa, prot} per the requirements.
    function automatic logic [36:0] model(bit leg, logic [31:0] ea, logic [1:0] acc, bit user);
        int          b;
        bit          found;
        logic [31:0] m, up, lo, pa;
        logic [2:0]  pr, need;
        bit          v;
        b = (acc == 2'd2) ? 1 : 0;
        found = 1'b0; pa = '0; pr = '0;
        for (int i = 0; i < 4; i++) begin
            up = sh_up[b][i]; lo = sh_lo[b][i];
            if (leg) begin
                v = lo[6];
                m = 32'hFFFE_0000;
                for (int j = 0; j < 6; j++) if (lo[j]) m[17+j] = 1'b0;
            end else begin
                v = user ? up[0] : up[1];
                m = 32'hF000_0000 | ({21'd0, ~up[12:2]} << 17);
            end
            if (!found && v && (((ea ^ up) & m) == 32'd0)) begin
                found = 1'b1;
                pa = (lo & m) | (ea & ~m);
                pr = leg ? rt(user ? up[2] : up[3], up[1:0]) : rt(1'b1, lo[1:0]);
            end
        end
        case (acc)
            2'd0: need = 3'b100;
            2'd1: need = 3'b010;
            2'd2: need = 3'b001;
            default: need = 3'b000;
        endcase
        return {found, found && ((need & ~pr) != 3'b000), pa, pr};
    endfunction

    function automatic logic [31:0] up_w(logic [14:0] pg, logic [10:0] bl, bit sv, bit uv);
        return {pg, 4'b0000, bl, sv, uv};
    endfunction

    function automatic logic [31:0] lo_w(logic [14:0] ppn, logic [16:0] misc);
        return {ppn, misc};
    endfunction

    task automatic wr(bit ib, int idx, bit isup, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_instr = ib; wr_idx = idx[1:0]; wr_upper = isup; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (isup) sh_up[ib][idx] = d; else sh_lo[ib][idx] = d;
    endtask

    task automatic look(string tag, logic [31:0] ea, logic [1:0] acc, bit user);
        logic [36:0] es, el;
        @(negedge clk);
        req = 1'b1; req_ea = ea; req_acc = acc; req_user = user;
        es = model(1'b0, ea, acc, user);
        el = model(1'b1, ea, acc, user);
        @(negedge clk);
        req = 1'b0;
        chk(tag, "standard", {s_valid, s_hit, s_viol, s_pa, s_prot}, {1'b1, es});
        chk({tag, "/R11/R12"}, "legacy", {l_valid, l_hit, l_viol, l_pa, l_prot}, {1'b1, el});
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [36:0] es, el;
        rst = 1'b1; wr_en = 0; wr_instr = 0; wr_idx = 0; wr_upper = 0; wr_data = 0;
        req = 0; req_ea = 0; req_acc = 0; req_user = 0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 4; i++) begin sh_up[b][i] = '0; sh_lo[b][i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "standard", {37'd0, s_valid}, 38'd0);
        chk("R1", "legacy",   {37'd0, l_valid}, 38'd0);
        rst = 1'b0;
        look("R1", 32'h0024_0000, 2'd0, 1'b0);
        look("R1", 32'h0040_1234, 2'd2, 1'b1);

        // Data bank
        wr(0, 0, 1, up_w(15'h010, 11'h003, 1, 0)); wr(0, 0, 0, lo_w(15'h400, 17'h42));
        wr(0, 1, 1, up_w(15'h012, 11'h000, 1, 1)); wr(0, 1, 0, lo_w(15'h500, 17'h41));
        wr(0, 2, 1, up_w(15'h100, 11'h0FF, 0, 1)); wr(0, 2, 0, lo_w(15'h7F00, 17'h00));
        wr(0, 3, 1, up_w(15'h080, 11'h01F, 1, 1)); wr(0, 3, 0, lo_w(15'h0A0, 17'h43));
        // Instruction bank
        wr(1, 0, 1, up_w(15'h020, 11'h007, 1, 1)); wr(1, 0, 0, lo_w(15'h300, 17'h41));
        wr(1, 1, 1, up_w(15'h0C0, 11'h000, 1, 0)); wr(1, 1, 0, lo_w(15'h0C8, 17'h40));

        // Sweep: R2 R3 R4 R5 R6 R7
        for (int pg = 0; pg < 512; pg++)
            for (int a = 0; a < 3; a++)
                for (int u = 0; u < 2; u++) begin
                    logic [16:0] low;
                    low = 17'(((pg * 37 + a * 5 + u) * 1021) & 32'h1FFFF);
                    look("R2/R3/R4/R5/R6/R7", {6'd0, 9'(pg), low}, 2'(a), u[0]);
                end

        // R6 hand-computed: supervisor load on page 0x012, entry 0 wins
        @(negedge clk);
        req = 1; req_ea = {15'h012, 17'h00155}; req_acc = 0; req_user = 0;
        @(negedge clk);
        req = 0;
        chk("R6", "standard", {s_valid, s_hit, s_viol, s_pa, s_prot},
            {3'b110, 15'h402, 17'h00155, 3'b111});
        // R9: valid drops in the idle cycle
        @(negedge clk);
        chk("R9", "standard", {37'd0, s_valid}, 38'd0);
        chk("R9", "legacy",   {37'd0, l_valid}, 38'd0);

        // R8 hand-computed miss
        @(negedge clk);
        req = 1; req_ea = {15'h300, 17'h1ABCD}; req_acc = 1; req_user = 0;
        @(negedge clk);
        req = 0;
        chk("R8", "standard", {s_valid, s_hit, s_viol, s_pa, s_prot}, {1'b1, 37'd0});

        // R7 hand-computed: store into read+execute block violates
        @(negedge clk);
        req = 1; req_ea = {15'h085, 17'h00010}; req_acc = 1; req_user = 1;
        @(negedge clk);
        req = 0;
        chk("R7", "standard", {s_valid, s_hit, s_viol, s_pa, s_prot},
            {3'b111, 15'h0A5, 17'h00010, 3'b101});

        // R10: write and lookup in the same cycle
        @(negedge clk);
        req = 1; req_ea = {15'h012, 17'h00077}; req_acc = 0; req_user = 1;
        wr_en = 1; wr_instr = 0; wr_idx = 2'd1; wr_upper = 1; wr_data = up_w(15'h012, 11'h000, 0, 0);
        es = model(1'b0, req_ea, 2'd0, 1'b1);
        el = model(1'b1, req_ea, 2'd0, 1'b1);
        @(negedge clk);
        req = 0; wr_en = 0;
        sh_up[0][1] = up_w(15'h012, 11'h000, 0, 0);
        chk("R10", "standard", {s_valid, s_hit, s_viol, s_pa, s_prot},
            {3'b110, 15'h500, 17'h00077, 3'b101});
        chk("R10", "standard-model", {1'b1, es}, {3'b110, 15'h500, 17'h00077, 3'b101});
        chk("R10", "legacy", {l_valid, l_hit, l_viol, l_pa, l_prot}, {1'b1, el});
        @(negedge clk);
        req = 1;
        @(negedge clk);
        req = 0;
        chk("R10", "standard", {s_valid, s_hit, s_viol, s_pa, s_prot}, {1'b1, 37'd0});
        look("R10", {15'h012, 17'h00077}, 2'd0, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule